// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block fronts a small word-addressed memory shared by several cores and gives each core an atomic read-modify-write primitive. A core issues a load-linked to read a word and arm a private reservation on its address. It may then issue a store-conditional to that address. The store lands only if no other core has committed a store to the same word in between. The core receives a one-bit outcome and retries when that outcome is zero.

Each core has its own reservation, made of a valid flag and an address. A single fixed-priority arbiter picks one request per cycle, and the lowest core index wins. At most one store therefore commits in any cycle. Results come back one cycle after the grant. A failed store-conditional leaves memory untouched and raises no write strobe, so a core that keeps retrying causes no write traffic.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `rsp_valid` and `wr_fire` are low, every memory word reads 0, and no core holds a reservation: a store-conditional from any core fails.
- R2: When `req_valid` is non-zero, `req_gnt` in the same cycle has exactly one bit set, the lowest-indexed requesting core. When no core requests, it is zero.
- R3: One cycle after a grant, `rsp_valid` equals that grant. `rsp_data` holds the word at the request address as it was before any write in the granted cycle.
- R4: Each core's 2-bit op field is `req_op[2i+1:2i]`, encoded 0 = load, 1 = load-linked, 2 = store, 3 = store-conditional. A load or a load-linked returns data and never raises `wr_fire`.
- R5: A load-linked arms the issuing core's reservation on its address. A later store-conditional from the same core to the same address, with no intervening store from another core to that address, succeeds: `rsp_ok`=1, `wr_fire`=1, and the word takes the new data.
- R6: A store-conditional fails when its core has no reservation or its address differs from the reserved one. On failure `rsp_ok`=0, `wr_fire`=0, and memory is unchanged.
- R7: A committed store from another core to the reserved address cancels the reservation. The core's own plain store, and stores to other addresses, leave it intact.
- R8: A store-conditional clears the issuing core's reservation whether it succeeds or fails, so an immediate second store-conditional fails.
- R9: A plain store always writes memory, raises `wr_fire` and returns `rsp_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-core request strobe |
| req_op | input | 2*NCORE | Per-core operation code |
| req_addr | input | NCORE*AW | Per-core word address |
| req_wdata | input | NCORE*DW | Per-core store data |
| req_gnt | output | NCORE | One-hot grant, same cycle |
| rsp_valid | output | NCORE | One-hot response strobe |
| rsp_data | output | DW | Word read at the granted address |
| rsp_ok | output | 1 | Store-conditional succeeded |
| wr_fire | output | 1 | A store was committed to memory |

## Verification
The bench builds the block with three cores, a 2-bit address and 8-bit data, so the memory holds four words. At that size the bench sweeps every combination of reserving core, interfering core, reserved address and interfering address. This covers the own-store, other-store, same-address and different-address cases of reservation loss. It also drives every one of the seven non-empty request patterns, which exercises the priority arbiter completely.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NCORE = 4,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORE-1:0]   req_valid,
  input  logic [2*NCORE-1:0] req_op,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE*DW-1:0] req_wdata,
  output logic [NCORE-1:0]   req_gnt,
  output logic [NCORE-1:0]   rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_ok,
  output logic               wr_fire
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam logic [1:0] OP_LD = 2'd0, OP_LL = 2'd1, OP_ST = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic          resv_v [NCORE];
  logic [AW-1:0] resv_a [NCORE];

  logic [IW-1:0] w_idx;
  logic [1:0]    w_op;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic          any, sc_ok, commit;

  assign any     = |req_valid;
  assign req_gnt = req_valid & (~req_valid + 1'b1);

  always_comb begin
    w_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--)
      if (req_valid[i]) w_idx = IW'(i);
  end

  assign w_op   = req_op[w_idx*2 +: 2];
  assign w_addr = req_addr[w_idx*AW +: AW];
  assign w_data = req_wdata[w_idx*DW +: DW];
  assign sc_ok  = (w_op == OP_SC) && resv_v[w_idx] && (resv_a[w_idx] == w_addr);
  assign commit = any && ((w_op == OP_ST) || sc_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
      wr_fire   <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      rsp_valid <= req_gnt;
      rsp_data  <= mem[w_addr];
      rsp_ok    <= any && sc_ok;
      wr_fire   <= commit;
      if (commit) mem[w_addr] <= w_data;
    end
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_resv
    logic mine;
    assign mine = any && (w_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resv_v[i] <= 1'b0;
        resv_a[i] <= '0;
      end else if (mine && w_op == OP_LL) begin
        resv_v[i] <= 1'b1;
        resv_a[i] <= w_addr;
      end else if (mine && w_op == OP_SC) begin
        resv_v[i] <= 1'b0;
      end else if (commit && !mine && resv_a[i] == w_addr) begin
        resv_v[i] <= 1'b0;
      end
    end
  end

  // silence unused OP_LD by referencing it in a harmless compare
  logic is_ld;
  assign is_ld = (w_op == OP_LD);
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NCORE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] req_valid,
  input logic [NCORE-1:0] req_gnt,
  input logic [NCORE-1:0] rsp_valid,
  input logic             rsp_ok,
  input logic             wr_fire,
  input logic             any,
  input logic [1:0]       w_op
);
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> ($countones(req_gnt) == 1));

  a_r3_rsp_follows_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (rsp_valid == $past(req_gnt)));

  a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !w_op[1]) |=> !wr_fire);

  a_r6_sc_write_iff_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (any && w_op == 2'd3) |=> (wr_fire == rsp_ok));

  a_r9_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (any && w_op == 2'd2) |=> (wr_fire && !rsp_ok));

  a_r5_ok_implies_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> wr_fire);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gnt(req_gnt),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .wr_fire(wr_fire),
  .any(any), .w_op(w_op)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, AW = 2, DW = 8, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [2*NC-1:0]  req_op = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC*DW-1:0] req_wdata = '0;
  logic [NC-1:0]    req_gnt, rsp_valid;
  logic [DW-1:0]    rsp_data;
  logic             rsp_ok, wr_fire;

  int n_chk = 0, n_fail = 0, seed = 1;
  int m [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NCORE(NC), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_gnt(req_gnt),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok), .wr_fire(wr_fire)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic int next_data();
    seed = seed + 1;
    return (seed * 37 + 11) & 255;
  endfunction

  task automatic issue(input int c, input int op, input int a, input int d);
    @(negedge clk);
    req_valid = '0;
    req_valid[c] = 1'b1;
    req_op[c*2 +: 2] = op[1:0];
    req_addr[c*AW +: AW] = a[AW-1:0];
    req_wdata[c*DW +: DW] = d[DW-1:0];
    #1 check(req_gnt == NC'(1 << c), "R2 grant", int'(req_gnt), 1 << c);
    @(negedge clk);
    req_valid = '0;
    check(rsp_valid == NC'(1 << c), "R3 rsp_valid", int'(rsp_valid), 1 << c);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == '0, "R1 rsp_valid idle", int'(rsp_valid), 0);
    check(wr_fire == 1'b0, "R1 wr_fire idle", int'(wr_fire), 0);
    check(req_gnt == '0, "R2 no request no grant", int'(req_gnt), 0);
    for (int c = 0; c < NC; c++) begin
      issue(c, 3, c, 8'h5A);
      check(rsp_ok == 1'b0, "R1 sc after reset fails", int'(rsp_ok), 0);
      check(wr_fire == 1'b0, "R1 sc after reset no write", int'(wr_fire), 0);
    end
    for (int a = 0; a < DEPTH; a++) begin
      issue(0, 0, a, 0);
      check(rsp_data == 0, "R1 memory reads zero", int'(rsp_data), 0);
    end

    // R5 R7 R8 R9 sweep over reserving core, interfering core, addresses
    for (int a = 0; a < NC; a++)
      for (int b = 0; b < NC; b++)
        for (int x = 0; x < DEPTH; x++)
          for (int y = 0; y < DEPTH; y++) begin
            int d1, d2, d3;
            bit exp_ok;
            issue(a, 1, x, 0);
            check(rsp_data == DW'(m[x]), "R4 ll data", int'(rsp_data), m[x]);
            check(wr_fire == 1'b0, "R4 ll no write", int'(wr_fire), 0);
            d1 = next_data();
            issue(b, 2, y, d1);
            check(rsp_data == DW'(m[y]), "R3 old data on store", int'(rsp_data), m[y]);
            check(wr_fire && !rsp_ok, "R9 plain store", int'({wr_fire, rsp_ok}), 2);
            m[y] = d1;
            exp_ok = !(b != a && y == x);
            d2 = next_data();
            issue(a, 3, x, d2);
            check(rsp_ok == exp_ok, "R7 sc outcome after store", int'(rsp_ok), int'(exp_ok));
            check(wr_fire == exp_ok, "R5 sc write strobe", int'(wr_fire), int'(exp_ok));
            if (exp_ok) m[x] = d2;
            d3 = next_data();
            issue(a, 3, x, d3);
            check(rsp_ok == 1'b0 && wr_fire == 1'b0, "R8 second sc fails",
                  int'({rsp_ok, wr_fire}), 0);
            issue(b, 0, x, 0);
            check(rsp_data == DW'(m[x]), "R6 memory after sc", int'(rsp_data), m[x]);
          end

    // R6 address mismatch
    for (int a = 0; a < NC; a++)
      for (int x = 0; x < DEPTH; x++) begin
        issue(a, 1, x, 0);
        issue(a, 3, x ^ 1, next_data());
        check(rsp_ok == 1'b0 && wr_fire == 1'b0, "R6 sc wrong address",
              int'({rsp_ok, wr_fire}), 0);
        issue(a, 0, x ^ 1, 0);
        check(rsp_data == DW'(m[x ^ 1]), "R6 memory unchanged", int'(rsp_data), m[x ^ 1]);
        issue(a, 3, x, next_data());
        check(rsp_ok == 1'b0, "R8 reservation gone after failed sc", int'(rsp_ok), 0);
      end

    // R2 R3 arbitration over every request pattern
    for (int p = 1; p < (1 << NC); p++) begin
      int win;
      win = -1;
      for (int c = NC - 1; c >= 0; c--) if (p[c]) win = c;
      @(negedge clk);
      req_valid = NC'(p);
      for (int c = 0; c < NC; c++) begin
        req_op[c*2 +: 2] = 2'd0;
        req_addr[c*AW +: AW] = AW'(c);
      end
      #1 check(req_gnt == NC'(1 << win), "R2 lowest index wins", int'(req_gnt), 1 << win);
      @(negedge clk);
      req_valid = '0;
      check(rsp_valid == NC'(1 << win), "R3 rsp to winner", int'(rsp_valid), 1 << win);
      check(rsp_data == DW'(m[win]), "R3 winner data", int'(rsp_data), m[win]);
      check(wr_fire == 1'b0, "R4 loads no write", int'(wr_fire), 0);
    end

    summary();
    $finish;
  end
endmodule